// File: doc/BRIEF.md
# Downspread Spectrum Modulation Controller

This block drives the fractional feedback divider of a clock synthesizer with a slow triangular offset. The offset only pulls the divider setting downward, so the synthesized clock sweeps from its nominal frequency down to nominal minus a programmed margin and back. Spreading the energy this way lowers the peak emission of the core and bus clocks. The analog loop, the oscillator and the loop filter lie outside the block. It consumes only a one-cycle tick taken from the reference oscillator and produces a signed offset word that is added to the divider.

A prescaler divides the reference ticks down to profile steps. An up/down position counter walks from zero to a peak and back. A scaler multiplies the position by the programmed depth to form the offset. Spreading is requested by holding an active-low select pin low, and that pin passes through a synchronizer. When the pin is released, the profile finishes by ramping back toward zero on the rising slope and then parks at zero. A new depth is accepted at any time, but it comes into use only while the profile sits at its zero point.

With the default parameters (14 ticks per step, 16 steps per slope), one period takes 448 reference ticks. From a 14.318 MHz reference this gives about 31.96 kHz. A depth of 150 divider LSBs is the ceiling and stands for 0.6 % of the divider word.

Top module: `dsm_spread_ctrl`

## Requirements
- R1: While reset is held and right after its release, `div_offset` is 0 and `phase` is 2'b00.
- R2: When `spread_sel_n` is high (as seen after `SYNC_STAGES` clock cycles) and the profile is at its zero point, reference ticks leave `div_offset` at 0 and `phase` at 2'b00.
- R3: The profile moves by exactly one position for every `PRESCALE` clock cycles in which `ref_tick` is high. Cycles with `ref_tick` low do not count and leave the outputs unchanged.
- R4: While spreading, the position sequence is 0, 1, …, 2^STEP_LG, 2^STEP_LG−1, …, 1, 0, repeating with a period of 2·2^STEP_LG steps. `div_offset` equals −floor(position·depth / 2^STEP_LG).
- R5: `div_offset` is never positive, and its magnitude never exceeds the depth in use.
- R6: Each step changes the position by exactly one, up or down, so the offset never jumps.
- R7: If `spread_sel_n` goes high during the falling slope, the next step already reduces the position. The profile then descends to zero and stays there with `phase` 2'b00.
- R8: A write (`depth_wr` high for one cycle with `depth_in`) stores min(`depth_in`, `MAX_DEPTH`).
- R9: A stored depth comes into use only while the profile is at its zero point. The offsets of a slope already in progress keep using the old depth.
- R10: `phase` encodes the slope. 2'b00 means the zero point, 2'b01 means a step moving away from nominal (position rising), and 2'b10 means a step moving back toward nominal (position falling). `phase` never has both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| spread_sel_n | input | 1 | Active-low spread request, asynchronous |
| depth_wr | input | 1 | Depth write strobe |
| depth_in | input | DEPTH_W | Requested peak depth in divider LSBs |
| div_offset | output | DEPTH_W+1 | Signed two's-complement divider offset, zero or negative |
| phase | output | 2 | Profile slope indicator |

## Verification
The bench builds the block with `PRESCALE`=3, `STEP_LG`=2 (four steps per slope) and `MAX_DEPTH`=100. With these values a whole triangle period, both turnarounds, the park at zero and a second period all fit into a few hundred cycles. A depth of 100 gives exact multiples of 25 along the profile. A depth of 37 exposes the floor rounding. A write of 200 runs into the clamp. The mid-slope disable, the postponed depth update and the tick gating are all reached within the first periods.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // Slope indicator driven on the phase port
  typedef enum logic [1:0] {
    PH_ZERO = 2'b00,
    PH_FALL = 2'b01,
    PH_RISE = 2'b10
  } dsm_phase_e;
endpackage

// File: rtl/dsm_prescaler.sv
module dsm_prescaler #(
  parameter int PRESCALE = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic step_en
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign step_en = tick & ~clear & (cnt_q == LAST);

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_tick_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q) || cnt_q == '0);
endmodule

// File: rtl/dsm_profile.sv
module dsm_profile
  import dsm_pkg::*;
#(
  parameter int STEP_LG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             spread_on,
  output logic [STEP_LG:0] pos,
  output dsm_phase_e       phase,
  output logic             at_zero
);
  localparam logic [STEP_LG:0] PEAK = (STEP_LG+1)'(1) << STEP_LG;
  localparam logic [STEP_LG:0] ONE  = (STEP_LG+1)'(1);

  dsm_phase_e       state_q, state_d;
  logic [STEP_LG:0] pos_q, pos_d;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    if (step_en) begin
      unique case (state_q)
        PH_ZERO: begin
          if (spread_on) begin
            state_d = PH_FALL;
            pos_d   = pos_q + 1'b1;
          end
        end
        PH_FALL: begin
          if (spread_on) begin
            if (pos_q == PEAK) begin
              state_d = PH_RISE;
              pos_d   = pos_q - 1'b1;
            end else begin
              pos_d   = pos_q + 1'b1;
            end
          end else begin
            // Release mid-slope: turn around at once
            pos_d   = pos_q - 1'b1;
            state_d = (pos_q == ONE) ? PH_ZERO : PH_RISE;
          end
        end
        PH_RISE: begin
          pos_d   = pos_q - 1'b1;
          state_d = (pos_q == ONE) ? PH_ZERO : PH_RISE;
        end
        default: begin
          state_d = PH_ZERO;
          pos_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_ZERO;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  assign pos     = pos_q;
  assign phase   = state_q;
  assign at_zero = (state_q == PH_ZERO);

  p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= PEAK);
  p_zero_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_ZERO) |-> (pos_q == '0));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pos_q) && $stable(state_q));
  p_unit_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (spread_on || state_q != PH_ZERO)) |=>
      (pos_q == $past(pos_q) + 1'b1) || (pos_q == $past(pos_q) - 1'b1));
  p_release_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !spread_on && state_q != PH_ZERO) |=> pos_q < $past(pos_q));
  p_phase_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(state_q));
endmodule

// File: rtl/dsm_depth_scale.sv
module dsm_depth_scale #(
  parameter int DEPTH_W   = 8,
  parameter int STEP_LG   = 4,
  parameter int MAX_DEPTH = 150,
  parameter int RST_DEPTH = 150
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [DEPTH_W-1:0]        din,
  input  logic                      at_zero,
  input  logic [STEP_LG:0]          pos,
  output logic signed [DEPTH_W:0]   offset
);
  localparam int PROD_W = STEP_LG + DEPTH_W + 1;
  localparam logic [DEPTH_W-1:0] MAX_D = DEPTH_W'(MAX_DEPTH);
  localparam logic [DEPTH_W-1:0] RST_D = DEPTH_W'(RST_DEPTH);

  logic [DEPTH_W-1:0] pend_q, pend_d;
  logic [DEPTH_W-1:0] act_q, act_d;
  logic [PROD_W-1:0]  prod;
  logic [DEPTH_W-1:0] mag;
  logic               unused_prod_bits;

  always_comb begin
    pend_d = pend_q;
    if (wr) pend_d = (din > MAX_D) ? MAX_D : din;
  end

  always_comb begin
    act_d = act_q;
    if (at_zero) act_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_D;
      act_q  <= RST_D;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign prod   = PROD_W'(pos) * PROD_W'(act_q);
  assign mag    = prod[STEP_LG +: DEPTH_W];
  assign unused_prod_bits = ^{prod[PROD_W-1], prod[STEP_LG-1:0]};
  assign offset = -$signed({1'b0, mag});

  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= MAX_D && act_q <= MAX_D);
  p_depth_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> $stable(act_q));
  p_never_positive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    offset <= 0);
  p_within_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    offset >= -$signed({1'b0, act_q}));
endmodule

// File: rtl/dsm_spread_ctrl.sv
module dsm_spread_ctrl
  import dsm_pkg::*;
#(
  parameter int PRESCALE    = 14,
  parameter int STEP_LG     = 4,
  parameter int DEPTH_W     = 8,
  parameter int MAX_DEPTH   = 150,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick,
  input  logic                    spread_sel_n,
  input  logic                    depth_wr,
  input  logic [DEPTH_W-1:0]      depth_in,
  output logic signed [DEPTH_W:0] div_offset,
  output logic [1:0]              phase
);
  logic [SYNC_STAGES-1:0] sel_sync_q;
  logic                   spread_on;
  logic                   step_en;
  logic                   at_zero;
  logic                   pre_clear;
  logic [STEP_LG:0]       pos;
  dsm_phase_e             phase_e;

  // Synchronizer chain for the asynchronous select pin, parked high (off)
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sel_sync_q[gi] <= 1'b1;
          else        sel_sync_q[gi] <= spread_sel_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sel_sync_q[gi] <= 1'b1;
          else        sel_sync_q[gi] <= sel_sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign spread_on = ~sel_sync_q[SYNC_STAGES-1];
  // Hold the step phase while parked and released, so a restart is aligned
  assign pre_clear = at_zero & ~spread_on;

  dsm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ref_tick),
    .clear   (pre_clear),
    .step_en (step_en)
  );

  dsm_profile #(.STEP_LG(STEP_LG)) u_prof (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .spread_on (spread_on),
    .pos       (pos),
    .phase     (phase_e),
    .at_zero   (at_zero)
  );

  dsm_depth_scale #(
    .DEPTH_W   (DEPTH_W),
    .STEP_LG   (STEP_LG),
    .MAX_DEPTH (MAX_DEPTH),
    .RST_DEPTH (MAX_DEPTH)
  ) u_depth (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (depth_wr),
    .din     (depth_in),
    .at_zero (at_zero),
    .pos     (pos),
    .offset  (div_offset)
  );

  assign phase = phase_e;

  p_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !spread_on) |=> (div_offset == '0) && (phase == 2'b00));
  p_zero_at_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00) |-> (div_offset == '0));
endmodule

// File: tb/dsm_spread_ctrl_tb.sv
module dsm_spread_ctrl_tb;
  localparam int PRESCALE = 3;
  localparam int STEP_LG  = 2;
  localparam int DEPTH_W  = 8;
  localparam int MAXD     = 100;
  localparam int NVEC     = 10;

  // Expected offset and phase after each step of a run from zero, depth 100
  localparam int EXP_OFS [NVEC] = '{-25, -50, -75, -100, -75, -50, -25, 0, -25, -50};
  localparam int EXP_PH  [NVEC] = '{1, 1, 1, 1, 2, 2, 2, 0, 1, 1};

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    ref_tick = 1'b0;
  logic                    spread_sel_n = 1'b1;
  logic                    depth_wr = 1'b0;
  logic [DEPTH_W-1:0]      depth_in = '0;
  logic signed [DEPTH_W:0] div_offset;
  logic [1:0]              phase;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dsm_spread_ctrl #(
    .PRESCALE(PRESCALE), .STEP_LG(STEP_LG), .DEPTH_W(DEPTH_W),
    .MAX_DEPTH(MAXD), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .spread_sel_n(spread_sel_n),
    .depth_wr(depth_wr), .depth_in(depth_in), .div_offset(div_offset), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input int exp_ofs, input int exp_ph);
    check({req, " offset"}, int'(div_offset), exp_ofs);
    check({req, " phase"}, int'(phase), exp_ph);
  endtask

  task automatic tick1();
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
  endtask

  task automatic step();
    for (int i = 0; i < PRESCALE; i++) tick1();
  endtask

  task automatic write_depth(input int v);
    @(negedge clk);
    depth_wr = 1'b1;
    depth_in = DEPTH_W'(v);
    @(negedge clk);
    depth_wr = 1'b0;
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk) spread_sel_n = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release", 0, 0);

    // R2: released select ignores ticks at the zero point
    step(); step();
    check_out("R2 parked", 0, 0);

    write_depth(100);
    set_sel(1'b0);
    check_out("R3 no tick yet", 0, 0);

    // R4 R10 table walk over a full period and into the next
    for (int k = 0; k < NVEC; k++) begin
      step();
      check_out($sformatf("R4 R10 vec %0d", k), EXP_OFS[k], EXP_PH[k]);
    end

    // R9: new depth mid-slope waits for the zero point
    write_depth(40);
    step(); check_out("R9 old depth pos3", -75, 1);
    step(); check_out("R9 old depth peak", -100, 1);
    step(); step(); step();
    check_out("R9 old depth rise", -25, 2);
    step(); check_out("R9 zero point", 0, 0);
    step(); check_out("R9 new depth used", -10, 1);
    step(); check_out("R6 unit step", -20, 1);

    // R7: release during the falling slope
    set_sel(1'b1);
    check_out("R7 waits for step", -20, 1);
    step(); check_out("R7 turned back", -10, 2);
    step(); check_out("R7 reached zero", 0, 0);
    step(); step();
    check_out("R7 R2 stays parked", 0, 0);

    // R8: clamp
    write_depth(200);
    set_sel(1'b0);
    step(); check_out("R8 clamped depth", -25, 1);

    // R3: idle cycles and partial tick counts
    repeat (20) @(negedge clk);
    check_out("R3 no ticks", -25, 1);
    tick1(); tick1();
    check_out("R3 partial ticks", -25, 1);
    tick1();
    check_out("R3 full count", -50, 1);

    // R4: floor rounding with depth 37
    write_depth(37);
    for (int i = 0; i < 6; i++) step();
    check_out("R4 back at zero", 0, 0);
    step(); check_out("R4 floor pos1", -9, 1);
    step(); check_out("R4 floor pos2", -18, 1);
    step(); check_out("R4 floor pos3", -27, 1);
    step(); check_out("R4 R5 floor peak", -37, 1);

    // R1: reset in the middle of a slope
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_out("R1 async reset", 0, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule